// File: doc/BRIEF.md
# Repeated String Operation Engine

This block sequences element-wide string operations against a synchronous memory port. A caller loads the source pointer, destination pointer, iteration count, accumulator and direction bit together with an operation code, an element width and a repeat mode, all in one start cycle. The engine then walks memory one element at a time, copying, loading, storing, comparing or scanning. It advances the pointers by the element width in the chosen direction and, for the two comparing operations, updates zero, carry and sign status bits.

The memory port has a one-cycle read latency. A read issued in one cycle returns its data in the next. A write takes effect at the clock edge where it is issued. Multi-byte elements are little-endian and never split into two accesses. A single-cycle completion pulse marks the end, and the final pointers, count, accumulator and status bits are on the outputs when the pulse is asserted.

Top module: `strop_engine`

## Requirements
- R1: `esize_i` selects the element width: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. The byte at the access address travels in `mem_rdata_i[7:0]`/`mem_wdata_o[7:0]`, and the following bytes go into the following lanes. A write enables exactly the low element-width lanes of `mem_wbe_o`.
- R2: After each iteration, a pointer that the operation steps moves by the element width. It moves up when the latched direction bit is 0 and down when it is 1, wrapping modulo 2^ADDR_W.
- R3: Copy (op 0) writes the element read at the source pointer to the destination pointer, then steps both pointers.
- R4: Load (op 1) puts the element at the source pointer into the low element-width bits of the accumulator, keeps the upper accumulator bits, and steps only the source pointer.
- R5: Store (op 2) writes the low element-width bits of the accumulator to the destination pointer and steps only the destination pointer.
- R6: Compare (op 3) computes source element minus destination element at element width. Zero is set on equality, carry on an unsigned borrow, and sign to the top bit of the difference. Both pointers step and memory is not written.
- R7: Scan (op 4) compares the low element-width bits of the accumulator against the destination element in the same way as R6. Only the destination pointer steps.
- R8: Repeat mode 0 runs exactly one iteration and leaves the count unchanged. Mode 1 decrements the count once per iteration and stops when it reaches zero. Each iteration issues one read for every element it reads and one write for every element it writes.
- R9: Mode 2 also stops after a compare or scan iteration that leaves zero clear. Mode 3 also stops after one that leaves zero set. For the other operations both modes behave like mode 1.
- R10: Two starts perform no memory access and pulse done on the next cycle with the loaded values on the outputs: a start with a nonzero repeat mode and a zero count, and a start with op codes 5 to 7.
- R11: While busy, a start is ignored. Done is high for exactly one cycle, with busy low. The status bits change only on compare or scan iterations and are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch request, honoured only when idle |
| op_i | input | 3 | Operation: 0 copy, 1 load, 2 store, 3 compare, 4 scan |
| esize_i | input | 2 | Element width code |
| rep_i | input | 2 | Repeat mode: 0 once, 1 count, 2 while equal, 3 while not equal |
| dir_i | input | 1 | Direction: 0 up, 1 down |
| si_i | input | ADDR_W | Initial source pointer |
| di_i | input | ADDR_W | Initial destination pointer |
| cx_i | input | CNT_W | Initial count |
| acc_i | input | 8*MAX_BYTES | Initial accumulator |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| si_o | output | ADDR_W | Source pointer |
| di_o | output | ADDR_W | Destination pointer |
| cx_o | output | CNT_W | Count |
| acc_o | output | 8*MAX_BYTES | Accumulator |
| zf_o | output | 1 | Zero status |
| cf_o | output | 1 | Carry (borrow) status |
| sf_o | output | 1 | Sign status |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_addr_o | output | ADDR_W | Byte address of the element |
| mem_wbe_o | output | MAX_BYTES | Write byte-lane enables |
| mem_wdata_o | output | 8*MAX_BYTES | Write data |
| mem_rdata_i | input | 8*MAX_BYTES | Read data, valid the cycle after the strobe |

## Verification
The bench builds the engine with ADDR_W=8, CNT_W=4 and MAX_BYTES=8. The whole 256-byte address space fits in a bench memory that is checked byte for byte after every run, and pointer wrap-around is reachable from a few start addresses. With this size the sweep covers every op code, element width, direction and repeat mode at counts of 0, 1, 2 and 5. The memory image is seeded so that compare and scan meet both equal and unequal elements, which exercises early exit in both conditional modes.

// File: rtl/strop_pkg.sv
package strop_pkg;

   localparam logic [2:0] OP_MOVE  = 3'd0;
   localparam logic [2:0] OP_LOAD  = 3'd1;
   localparam logic [2:0] OP_STORE = 3'd2;
   localparam logic [2:0] OP_CMP   = 3'd3;
   localparam logic [2:0] OP_SCAN  = 3'd4;

   localparam logic [1:0] REP_NONE = 2'd0;
   localparam logic [1:0] REP_ALL  = 2'd1;
   localparam logic [1:0] REP_WEQ  = 2'd2;
   localparam logic [1:0] REP_WNE  = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RDS  = 2'd1,
      ST_RDD  = 2'd2,
      ST_FIN  = 2'd3
   } strop_state_e;

   function automatic logic op_known(input logic [2:0] op);
      return op <= OP_SCAN;
   endfunction

   // first state of an iteration for a given operation
   function automatic strop_state_e entry_state(input logic [2:0] op);
      case (op)
         OP_STORE: return ST_FIN;
         OP_SCAN:  return ST_RDD;
         default:  return ST_RDS;
      endcase
   endfunction

endpackage

// File: rtl/strop_sizer.sv
module strop_sizer #(
   parameter int MAX_BYTES = 8
) (
   input  logic [1:0]               esize_i,
   output logic [MAX_BYTES-1:0]     lane_o,
   output logic [8*MAX_BYTES-1:0]   bits_o,
   output logic [8*MAX_BYTES-1:0]   sign_o,
   output logic [3:0]               nbytes_o
);
   localparam int LGB = $clog2(MAX_BYTES);

   logic [1:0] eff;

   // codes wider than the datapath clamp to the widest element
   assign eff      = (esize_i > 2'(LGB)) ? 2'(LGB) : esize_i;
   assign nbytes_o = 4'd1 << eff;

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      assign lane_o[g]        = 4'(g) < nbytes_o;
      assign bits_o[8*g +: 8] = {8{lane_o[g]}};
      assign sign_o[8*g +: 7] = '0;
      if (g == MAX_BYTES - 1) begin : g_top
         assign sign_o[8*g+7] = lane_o[g];
      end else begin : g_mid
         assign sign_o[8*g+7] = lane_o[g] & ~lane_o[g+1];
      end
   end

endmodule

// File: rtl/strop_ptr_step.sv
module strop_ptr_step #(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] ptr_i,
   input  logic [3:0]        nbytes_i,
   input  logic              dec_i,
   output logic [ADDR_W-1:0] ptr_o
);
   logic [ADDR_W-1:0] amt;

   assign amt   = ADDR_W'(nbytes_i);
   assign ptr_o = dec_i ? ptr_i - amt : ptr_i + amt;

endmodule

// File: rtl/strop_flags.sv
module strop_flags #(
   parameter int DW = 64
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic [DW-1:0] bits_i,
   input  logic [DW-1:0] sign_i,
   output logic          zf_o,
   output logic          cf_o,
   output logic          sf_o
);
   logic [DW:0] diff;

   assign diff = {1'b0, a_i & bits_i} - {1'b0, b_i & bits_i};
   assign zf_o = ((a_i ^ b_i) & bits_i) == '0;
   assign cf_o = diff[DW];
   assign sf_o = |(diff[DW-1:0] & sign_i);

endmodule

// File: rtl/strop_engine.sv
module strop_engine
   import strop_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int MAX_BYTES = 8
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   start_i,
   input  logic [2:0]             op_i,
   input  logic [1:0]             esize_i,
   input  logic [1:0]             rep_i,
   input  logic                   dir_i,
   input  logic [ADDR_W-1:0]      si_i,
   input  logic [ADDR_W-1:0]      di_i,
   input  logic [CNT_W-1:0]       cx_i,
   input  logic [8*MAX_BYTES-1:0] acc_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [ADDR_W-1:0]      si_o,
   output logic [ADDR_W-1:0]      di_o,
   output logic [CNT_W-1:0]       cx_o,
   output logic [8*MAX_BYTES-1:0] acc_o,
   output logic                   zf_o,
   output logic                   cf_o,
   output logic                   sf_o,
   output logic                   mem_rd_o,
   output logic                   mem_wr_o,
   output logic [ADDR_W-1:0]      mem_addr_o,
   output logic [MAX_BYTES-1:0]   mem_wbe_o,
   output logic [8*MAX_BYTES-1:0] mem_wdata_o,
   input  logic [8*MAX_BYTES-1:0] mem_rdata_i
);
   localparam int DW = 8 * MAX_BYTES;

   if (MAX_BYTES != 1 && MAX_BYTES != 2 && MAX_BYTES != 4 && MAX_BYTES != 8) begin : g_bad_bytes
      $error("strop_engine: MAX_BYTES must be 1, 2, 4 or 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("strop_engine: ADDR_W must be at least 4");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("strop_engine: CNT_W must be at least 1");
   end

   strop_state_e      state_q;
   logic [2:0]        op_q;
   logic [1:0]        sz_q;
   logic [1:0]        rep_q;
   logic              dir_q;
   logic [ADDR_W-1:0] si_q, di_q;
   logic [CNT_W-1:0]  cx_q;
   logic [DW-1:0]     acc_q, tmp_q;
   logic              zf_q, cf_q, sf_q, done_q;

   logic [MAX_BYTES-1:0] lane;
   logic [DW-1:0]        bits, sign;
   logic [3:0]           nbytes;
   logic                 zf_n, cf_n, sf_n;
   logic                 is_cmp, si_step, di_step, stop;
   logic [CNT_W-1:0]     cx_dec;
   logic [DW-1:0]        load_merge;
   logic [ADDR_W-1:0]    ptr_cur [2];
   logic [ADDR_W-1:0]    ptr_nxt [2];

   strop_sizer #(.MAX_BYTES(MAX_BYTES)) u_sizer (
      .esize_i  (sz_q),
      .lane_o   (lane),
      .bits_o   (bits),
      .sign_o   (sign),
      .nbytes_o (nbytes)
   );

   assign ptr_cur[0] = si_q;
   assign ptr_cur[1] = di_q;

   for (genvar p = 0; p < 2; p++) begin : g_step
      strop_ptr_step #(.ADDR_W(ADDR_W)) u_step (
         .ptr_i    (ptr_cur[p]),
         .nbytes_i (nbytes),
         .dec_i    (dir_q),
         .ptr_o    (ptr_nxt[p])
      );
   end

   strop_flags #(.DW(DW)) u_flags (
      .a_i    (tmp_q),
      .b_i    (mem_rdata_i),
      .bits_i (bits),
      .sign_i (sign),
      .zf_o   (zf_n),
      .cf_o   (cf_n),
      .sf_o   (sf_n)
   );

   assign is_cmp     = (op_q == OP_CMP) || (op_q == OP_SCAN);
   assign si_step    = (op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP);
   assign di_step    = (op_q != OP_LOAD);
   assign cx_dec     = cx_q - CNT_W'(1);
   assign load_merge = (acc_q & ~bits) | (mem_rdata_i & bits);
   assign stop       = (rep_q == REP_NONE) || (cx_dec == '0) ||
                       (is_cmp && (((rep_q == REP_WEQ) && !zf_n) ||
                                   ((rep_q == REP_WNE) && zf_n)));

   // memory port decode
   assign mem_rd_o    = (state_q == ST_RDS) || (state_q == ST_RDD);
   assign mem_wr_o    = (state_q == ST_FIN) && ((op_q == OP_MOVE) || (op_q == OP_STORE));
   assign mem_addr_o  = (state_q == ST_RDS) ? si_q : di_q;
   assign mem_wbe_o   = lane;
   assign mem_wdata_o = (op_q == OP_MOVE) ? mem_rdata_i : acc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         op_q    <= '0;
         sz_q    <= '0;
         rep_q   <= '0;
         dir_q   <= 1'b0;
         si_q    <= '0;
         di_q    <= '0;
         cx_q    <= '0;
         acc_q   <= '0;
         tmp_q   <= '0;
         zf_q    <= 1'b0;
         cf_q    <= 1'b0;
         sf_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  op_q  <= op_i;
                  sz_q  <= esize_i;
                  rep_q <= rep_i;
                  dir_q <= dir_i;
                  si_q  <= si_i;
                  di_q  <= di_i;
                  cx_q  <= cx_i;
                  acc_q <= acc_i;
                  if (!op_known(op_i) || ((rep_i != REP_NONE) && (cx_i == '0))) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= entry_state(op_i);
                  end
               end
            end
            ST_RDS: begin
               state_q <= (op_q == OP_CMP) ? ST_RDD : ST_FIN;
            end
            ST_RDD: begin
               // source element for compare, accumulator for scan
               tmp_q   <= (op_q == OP_CMP) ? mem_rdata_i : acc_q;
               state_q <= ST_FIN;
            end
            ST_FIN: begin
               if (op_q == OP_LOAD) acc_q <= load_merge;
               if (is_cmp) begin
                  zf_q <= zf_n;
                  cf_q <= cf_n;
                  sf_q <= sf_n;
               end
               if (si_step) si_q <= ptr_nxt[0];
               if (di_step) di_q <= ptr_nxt[1];
               if (rep_q != REP_NONE) cx_q <= cx_dec;
               if (stop) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  state_q <= entry_state(op_q);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign si_o   = si_q;
   assign di_o   = di_q;
   assign cx_o   = cx_q;
   assign acc_o  = acc_q;
   assign zf_o   = zf_q;
   assign cf_o   = cf_q;
   assign sf_o   = sf_q;

endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk #(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int MAX_BYTES = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic [1:0]        rep_i,
   input logic [CNT_W-1:0]  cx_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic [ADDR_W-1:0] si_o,
   input logic [ADDR_W-1:0] di_o,
   input logic [CNT_W-1:0]  cx_o,
   input logic              zf_o,
   input logic              cf_o,
   input logic              sf_o,
   input logic [2:0]        op_q,
   input logic [1:0]        sz_q,
   input logic              dir_q
);
   localparam int LGB = $clog2(MAX_BYTES);

   logic [1:0]        eff;
   logic [ADDR_W-1:0] stride;
   logic              cmp_like;

   assign eff      = (sz_q > 2'(LGB)) ? 2'(LGB) : sz_q;
   assign stride   = ADDR_W'(1) << eff;
   assign cmp_like = (op_q == 3'd3) || (op_q == 3'd4);

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !mem_rd_o && !mem_wr_o); // R10

   AST_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && start_i && rep_i != 2'd0 && cx_i == '0) |=> done_o && !busy_o); // R10

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R11

   AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o); // R11

   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && start_i) |=> $stable(op_q)); // R11

   AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !cmp_like) |=> $stable({zf_o, cf_o, sf_o})); // R11

   AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (cx_o == $past(cx_o)) || (cx_o == $past(cx_o) - CNT_W'(1))); // R8

   AST_SRC_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (si_o == $past(si_o)) ||
                 (si_o == ($past(dir_q) ? $past(si_o) - $past(stride)
                                        : $past(si_o) + $past(stride)))); // R2

   AST_DST_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (di_o == $past(di_o)) ||
                 (di_o == ($past(dir_q) ? $past(di_o) - $past(stride)
                                        : $past(di_o) + $past(stride)))); // R2

endmodule

bind strop_engine strop_engine_chk #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .start_i  (start_i),
   .rep_i    (rep_i),
   .cx_i     (cx_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .mem_rd_o (mem_rd_o),
   .mem_wr_o (mem_wr_o),
   .si_o     (si_o),
   .di_o     (di_o),
   .cx_o     (cx_o),
   .zf_o     (zf_o),
   .cf_o     (cf_o),
   .sf_o     (sf_o),
   .op_q     (op_q),
   .sz_q     (sz_q),
   .dir_q    (dir_q)
);

// File: tb/strop_engine_tb.sv
module strop_engine_tb;

   localparam int AW = 8;
   localparam int CW = 4;
   localparam int MB = 8;
   localparam int DW = 8 * MB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    op = '0;
   logic [1:0]    esize = '0;
   logic [1:0]    rep = '0;
   logic          dir = 1'b0;
   logic [AW-1:0] si_in = '0, di_in = '0;
   logic [CW-1:0] cx_in = '0;
   logic [DW-1:0] acc_in = '0;
   logic          busy, done, zf, cf, sf, mem_rd, mem_wr;
   logic [AW-1:0] si, di, mem_addr;
   logic [CW-1:0] cx;
   logic [DW-1:0] acc, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic [MB-1:0] mem_wbe;

   always #4 clk = ~clk;

   strop_engine #(.ADDR_W(AW), .CNT_W(CW), .MAX_BYTES(MB)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .esize_i(esize),
      .rep_i(rep), .dir_i(dir), .si_i(si_in), .di_i(di_in), .cx_i(cx_in),
      .acc_i(acc_in), .busy_o(busy), .done_o(done), .si_o(si), .di_o(di),
      .cx_o(cx), .acc_o(acc), .zf_o(zf), .cf_o(cf), .sf_o(sf),
      .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
      .mem_wbe_o(mem_wbe), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
   );

   // bench memory, owned by this process only
   logic [7:0] mem [256];
   logic       init_req = 1'b0;
   int         n_rd = 0, n_wr = 0;

   function automatic logic [7:0] pat(input int a);
      logic [7:0] v;
      v = 8'(a & 31);
      if (a == 8'hA2 || a == 8'h9E || a == 8'h44) v = v ^ 8'h80;
      return v;
   endfunction

   always @(posedge clk) begin
      if (init_req) begin
         for (int a = 0; a < 256; a++) mem[a] = pat(a);
      end
      if (mem_rd) begin
         for (int k = 0; k < MB; k++) mem_rdata[8*k +: 8] <= mem[8'(int'(mem_addr) + k)];
         n_rd++;
      end
      if (mem_wr) begin
         for (int k = 0; k < MB; k++)
            if (mem_wbe[k]) mem[8'(int'(mem_addr) + k)] = mem_wdata[8*k +: 8];
         n_wr++;
      end
   end

   int n_chk = 0, n_fail = 0;
   logic ezf = 1'b0, ecf = 1'b0, esf = 1'b0;

   task automatic check(input bit ok, input string tag, input string msg);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   task automatic run(input logic [2:0] t_op, input logic [1:0] t_sz, input logic [1:0] t_rep,
                      input logic t_dir, input logic [AW-1:0] t_si, input logic [AW-1:0] t_di,
                      input logic [CW-1:0] t_cx, input logic [DW-1:0] t_acc, input bit poke);
      logic [7:0]    rm [256];
      logic [AW-1:0] xsi, xdi;
      logic [CW-1:0] xcx;
      logic [DW-1:0] xacc, ea, eb, msk, d;
      int            n, xrd, xwr, rd0, wr0, cyc, bad;
      string         tag;
      // reference model from the requirements
      for (int a = 0; a < 256; a++) rm[a] = pat(a);
      n = 1 << t_sz;
      msk = (n == 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
      xsi = t_si; xdi = t_di; xcx = t_cx; xacc = t_acc; xrd = 0; xwr = 0;
      if (t_op <= 3'd4 && !(t_rep != 2'd0 && t_cx == '0)) begin
         for (int it = 0; it < 64; it++) begin
            ea = '0; eb = '0;
            for (int k = 0; k < n; k++) begin
               ea[8*k +: 8] = rm[8'(int'(xsi) + k)];
               eb[8*k +: 8] = rm[8'(int'(xdi) + k)];
            end
            case (t_op)
               3'd0: begin
                  for (int k = 0; k < n; k++) rm[8'(int'(xdi) + k)] = ea[8*k +: 8];
                  xrd++; xwr++;
               end
               3'd1: begin xacc = (xacc & ~msk) | ea; xrd++; end
               3'd2: begin
                  for (int k = 0; k < n; k++) rm[8'(int'(xdi) + k)] = xacc[8*k +: 8];
                  xwr++;
               end
               default: begin
                  if (t_op == 3'd4) begin ea = xacc & msk; xrd++; end
                  else xrd += 2;
                  d = ea - eb;
                  ezf = (ea == eb);
                  ecf = (ea < eb);
                  esf = d[8*n-1];
               end
            endcase
            if (t_op != 3'd2 && t_op != 3'd4) xsi = t_dir ? xsi - 8'(n) : xsi + 8'(n);
            if (t_op != 3'd1) xdi = t_dir ? xdi - 8'(n) : xdi + 8'(n);
            if (t_rep == 2'd0) break;
            xcx = xcx - 1'b1;
            if (xcx == '0) break;
            if (t_op >= 3'd3 && ((t_rep == 2'd2 && !ezf) || (t_rep == 2'd3 && ezf))) break;
         end
      end
      if (t_op > 3'd4 || (t_rep != 2'd0 && t_cx == '0)) tag = "R10";
      else if (t_rep >= 2'd2 && t_op >= 3'd3) tag = "R9";
      else if (t_op == 3'd0) tag = "R3";
      else if (t_op == 3'd1) tag = "R4";
      else if (t_op == 3'd2) tag = "R5";
      else if (t_op == 3'd3) tag = "R6";
      else tag = "R7";
      if (poke) tag = "R11";
      // drive the design
      @(negedge clk); init_req = 1'b1;
      @(negedge clk); init_req = 1'b0;
      rd0 = n_rd; wr0 = n_wr;
      op = t_op; esize = t_sz; rep = t_rep; dir = t_dir;
      si_in = t_si; di_in = t_di; cx_in = t_cx; acc_in = t_acc; start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (poke) begin
         op = 3'd2; si_in = 8'h11; di_in = 8'h22; cx_in = 4'd9; acc_in = '1; dir = ~t_dir;
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 400) begin @(negedge clk); cyc++; end
      check(done == 1'b1, tag, $sformatf("no done, act %0d exp 1", done));
      check(!busy && si == xsi && di == xdi && cx == xcx && acc == xacc &&
            zf == ezf && cf == ecf && sf == esf, {tag, " R1 R2"},
            $sformatf("op%0d sz%0d rep%0d dir%0d cx%0d: act si=%h di=%h cx=%0d acc=%h f=%b%b%b exp si=%h di=%h cx=%0d acc=%h f=%b%b%b",
                      t_op, t_sz, t_rep, t_dir, t_cx, si, di, cx, acc, zf, cf, sf,
                      xsi, xdi, xcx, xacc, ezf, ecf, esf));
      bad = 0;
      for (int a = 0; a < 256; a++) if (mem[a] !== rm[a]) bad++;
      check(bad == 0, {tag, " R1"}, $sformatf("memory bytes differing act %0d exp 0", bad));
      check(n_rd - rd0 == xrd && n_wr - wr0 == xwr, "R8",
            $sformatf("accesses act rd=%0d wr=%0d exp rd=%0d wr=%0d", n_rd - rd0, n_wr - wr0, xrd, xwr));
      @(negedge clk);
      check(done == 1'b0, "R11", $sformatf("done width act %0d exp 0", done));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog: act timeout exp finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      int cnts [4];
      cnts[0] = 0; cnts[1] = 1; cnts[2] = 2; cnts[3] = 5;
      repeat (3) @(negedge clk);
      check(!busy && !done && !zf && !cf && !sf && !mem_rd && !mem_wr, "R11",
            $sformatf("reset act busy=%0d done=%0d f=%b%b%b exp all 0", busy, done, zf, cf, sf));
      rst_n = 1'b1;
      for (int o = 0; o < 8; o++)
         for (int s = 0; s < 4; s++)
            for (int dd = 0; dd < 2; dd++)
               for (int r = 0; r < 4; r++)
                  for (int c = 0; c < 4; c++)
                     run(3'(o), 2'(s), 2'(r), 1'(dd), 8'h40, 8'hA0, 4'(cnts[c]),
                         64'hF7E6D5C4B3A29100, 1'b0);
      // wrap-around of both pointers (R2)
      for (int o = 0; o < 5; o++) begin
         run(3'(o), 2'd2, 2'd1, 1'b1, 8'h02, 8'h06, 4'd3, 64'h0123456789ABCDEF, 1'b0);
         run(3'(o), 2'd3, 2'd1, 1'b0, 8'hF8, 8'hF0, 4'd3, 64'h0123456789ABCDEF, 1'b0);
      end
      // start while busy is ignored (R11)
      run(3'd0, 2'd0, 2'd1, 1'b0, 8'h40, 8'hA0, 4'd5, 64'h55, 1'b1);
      run(3'd3, 2'd1, 2'd2, 1'b1, 8'h40, 8'hA0, 4'd5, 64'h55, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule